// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block serializes one character per accepted request onto a single output line. A character consists of a low start bit, then 4 to 16 data bits, then an optional parity bit, then a stop period. The format is chosen at run time through the data length, parity type, stop length, bit order and oversampling fields. The format fields are captured when a character is accepted, so a frame keeps a consistent shape even if they change while it is on the line.

All timing comes from `os_tick`. This is a one-clock strobe from an external oversampling divider, and the bit period is a whole number of these strobes. Line inversion, automatic tristate of the output driver and clear-to-send gating are applied at the line. A break request holds the line at the active level wherever data or parity would appear.

Top module: `frame_tx`

## Requirements
- R1: After reset the block is idle: `busy`=0, `frame_done`=0, `tx_line` is at its idle level (1, or 0 when `cfg_tx_inv`=1), and `in_ready`=1 whenever clear-to-send permits.
- R2: A frame is a start bit (logical 0), the data bits, the parity bit if enabled, and then the stop period (logical 1). Start, data and parity bits each last P ticks, where `cfg_ovs` codes 0,1,2,3 give P = 16, 8, 6, 4. The format fields are sampled when a character is accepted.
- R3: `cfg_len` code 1..13 selects code+3 data bits, from 4 up to 16. Bits of `in_data` above the selected length are not sent.
- R4: With `cfg_msb_first`=0 data goes out from bit 0 upward. With `cfg_msb_first`=1 it goes out from the highest selected bit downward.
- R5: `cfg_par` codes 0 and 1 send no parity bit. Code 2 sends even parity, which makes the number of ones in data plus parity even. Code 3 sends odd parity.
- R6: `cfg_stop` codes 0,1,2,3 make the stop period last P/2, P, 3P/2 and 2P ticks.
- R7: When `in_break`=1 at acceptance, every data and parity position is driven to logical 0. The start bit and the stop period are unchanged.
- R8: With `cfg_tx_inv`=1, `tx_line` is the inverse of the logical level at all times, including idle.
- R9: With `cfg_auto_tri`=1, `tx_oe`=0 while idle. `tx_oe`=1 during a frame, and always when `cfg_auto_tri`=0.
- R10: With `cfg_cts_en`=1, no frame starts and `in_ready`=0 while `cts` is negated. `cts` is asserted when low if `cfg_cts_inv`=0, and when high if `cfg_cts_inv`=1. With `cfg_cts_en`=0, `cts` is ignored.
- R11: A frame in progress completes unchanged if `cts` is negated partway through it.
- R12: A character is accepted on a clock where `in_valid` and `in_ready` are both 1. `in_ready`=0 while `busy`=1. `frame_done` is high for exactly one clock, the clock after the final stop tick, and `busy` drops in that same clock.
- R13: Frame timing advances only on clocks with `os_tick`=1. Without ticks the line holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_tick | input | 1 | Oversampling strobe |
| cfg_len | input | 4 | Data length code |
| cfg_par | input | 2 | Parity code |
| cfg_stop | input | 2 | Stop length code |
| cfg_ovs | input | 2 | Ticks-per-bit code |
| cfg_msb_first | input | 1 | Send most significant bit first |
| cfg_tx_inv | input | 1 | Invert line output |
| cfg_auto_tri | input | 1 | Disable driver while idle |
| cfg_cts_en | input | 1 | Enable clear-to-send gating |
| cfg_cts_inv | input | 1 | Clear-to-send active high |
| cts | input | 1 | Clear-to-send input |
| in_data | input | 16 | Character to send |
| in_break | input | 1 | Send this character as break |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character can be accepted |
| tx_line | output | 1 | Serial line |
| tx_oe | output | 1 | Line driver enable |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-clock end-of-frame pulse |

## Verification
Several properties are checked on every cycle:
- the idle line level under inversion;
- the disabled driver when idle with automatic tristate;
- the blocked start under negated clear-to-send;
- no readiness while busy;
- a single-clock done pulse that coincides with idle;
- a logical-0 level in the first busy cycle;
- a line that holds still on clocks without a tick.

Only the bench scenarios show that the complete waveform is right, tick for tick. That covers bit order, data length, the parity value, the four stop lengths, break substitution, completion despite a mid-frame clear-to-send drop, and the stretching of a frame by a stalled tick.

// File: rtl/frame_tx_pkg.sv
package frame_tx_pkg;

  localparam int FTX_DATA_W = 16;
  localparam int FTX_LEN_W  = 4;
  localparam int FTX_IDX_W  = $clog2(FTX_DATA_W + 1);
  localparam int FTX_CNT_W  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } ftx_state_e;

  function automatic logic [FTX_CNT_W-1:0] bit_ticks(input logic [1:0] ovs);
    case (ovs)
      2'd0:    bit_ticks = FTX_CNT_W'(16);
      2'd1:    bit_ticks = FTX_CNT_W'(8);
      2'd2:    bit_ticks = FTX_CNT_W'(6);
      default: bit_ticks = FTX_CNT_W'(4);
    endcase
  endfunction

  function automatic logic [FTX_CNT_W-1:0] stop_ticks(input logic [1:0] ovs,
                                                      input logic [1:0] stp);
    logic [FTX_CNT_W-1:0] p;
    p = bit_ticks(ovs);
    case (stp)
      2'd0:    stop_ticks = p >> 1;
      2'd1:    stop_ticks = p;
      2'd2:    stop_ticks = p + (p >> 1);
      default: stop_ticks = p << 1;
    endcase
  endfunction

  function automatic logic [FTX_IDX_W-1:0] data_bits(input logic [FTX_LEN_W-1:0] code);
    if (code == '0)
      data_bits = FTX_IDX_W'(4);
    else if (code > FTX_LEN_W'(13))
      data_bits = FTX_IDX_W'(16);
    else
      data_bits = FTX_IDX_W'(code) + FTX_IDX_W'(3);
  endfunction

endpackage

// File: rtl/ftx_baud_cnt.sv
module ftx_baud_cnt #(
  parameter int CNT_W = frame_tx_pkg::FTX_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             os_tick,
  input  logic [CNT_W-1:0] seg_ticks,
  output logic             seg_end
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == seg_ticks - CNT_W'(1));
  assign seg_end = run & os_tick & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)
      cnt_d = '0;
    else if (os_tick)
      cnt_d = at_last ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ftx_seq.sv
module ftx_seq
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = FTX_DATA_W,
  parameter int LEN_W  = FTX_LEN_W,
  parameter int IDX_W  = FTX_IDX_W,
  parameter int CNT_W  = FTX_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_break,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_ovs,
  input  logic              cfg_msb_first,
  input  logic              seg_end,
  output logic [CNT_W-1:0]  seg_ticks,
  output logic              line_raw,
  output logic              busy,
  output logic              frame_done
);

  localparam int SEL_W = $clog2(DATA_W);

  ftx_state_e        st_q, st_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic [IDX_W-1:0]  nb_q, nb_d;
  logic [CNT_W-1:0]  bitn_q, bitn_d, stopn_q, stopn_d;
  logic              brk_q, brk_d, pen_q, pen_d, podd_q, podd_d, msb_q, msb_d;
  logic              done_q, done_d;
  logic [IDX_W-1:0]  nb_new;
  logic [DATA_W-1:0] keep;
  logic [SEL_W-1:0]  sel;
  logic              par_bit;

  assign nb_new = data_bits(cfg_len);

  always_comb begin
    for (int i = 0; i < DATA_W; i++)
      keep[i] = (i < int'(nb_new));
  end

  assign sel     = msb_q ? SEL_W'(nb_q - idx_q - IDX_W'(1)) : SEL_W'(idx_q);
  assign par_bit = (^dat_q) ^ podd_q;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    dat_d   = dat_q;
    nb_d    = nb_q;
    bitn_d  = bitn_q;
    stopn_d = stopn_q;
    brk_d   = brk_q;
    pen_d   = pen_q;
    podd_d  = podd_q;
    msb_d   = msb_q;
    done_d  = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d    = ST_START;
        idx_d   = '0;
        dat_d   = in_data & keep;
        nb_d    = nb_new;
        bitn_d  = bit_ticks(cfg_ovs);
        stopn_d = stop_ticks(cfg_ovs, cfg_stop);
        brk_d   = in_break;
        pen_d   = cfg_par[1];
        podd_d  = cfg_par[0];
        msb_d   = cfg_msb_first;
      end
      ST_START: if (seg_end) st_d = ST_DATA;
      ST_DATA: if (seg_end) begin
        if (idx_q == nb_q - IDX_W'(1))
          st_d = pen_q ? ST_PAR : ST_STOP;
        else
          idx_d = idx_q + IDX_W'(1);
      end
      ST_PAR: if (seg_end) st_d = ST_STOP;
      ST_STOP: if (seg_end) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      idx_q   <= '0;
      dat_q   <= '0;
      nb_q    <= '0;
      bitn_q  <= '0;
      stopn_q <= '0;
      brk_q   <= 1'b0;
      pen_q   <= 1'b0;
      podd_q  <= 1'b0;
      msb_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      idx_q   <= idx_d;
      dat_q   <= dat_d;
      nb_q    <= nb_d;
      bitn_q  <= bitn_d;
      stopn_q <= stopn_d;
      brk_q   <= brk_d;
      pen_q   <= pen_d;
      podd_q  <= podd_d;
      msb_q   <= msb_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    case (st_q)
      ST_START: line_raw = 1'b0;
      ST_DATA:  line_raw = brk_q ? 1'b0 : dat_q[sel];
      ST_PAR:   line_raw = brk_q ? 1'b0 : par_bit;
      default:  line_raw = 1'b1;
    endcase
  end

  assign seg_ticks  = (st_q == ST_STOP) ? stopn_q : bitn_q;
  assign busy       = (st_q != ST_IDLE);
  assign frame_done = done_q;

endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import frame_tx_pkg::*;
#(
  parameter int DATA_W = FTX_DATA_W,
  parameter int LEN_W  = FTX_LEN_W,
  parameter int IDX_W  = FTX_IDX_W,
  parameter int CNT_W  = FTX_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [1:0]        cfg_par,
  input  logic [1:0]        cfg_stop,
  input  logic [1:0]        cfg_ovs,
  input  logic              cfg_msb_first,
  input  logic              cfg_tx_inv,
  input  logic              cfg_auto_tri,
  input  logic              cfg_cts_en,
  input  logic              cfg_cts_inv,
  input  logic              cts,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_break,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx_line,
  output logic              tx_oe,
  output logic              busy,
  output logic              frame_done
);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             cts_ok;
  logic             accept;
  logic             seg_end;
  logic [CNT_W-1:0] seg_ticks;
  logic             line_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign cts_ok   = ~cfg_cts_en | (cfg_cts_inv ? cts : ~cts);
  assign in_ready = ~busy & cts_ok;
  assign accept   = in_valid & in_ready;

  ftx_baud_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .run       (busy),
    .os_tick   (os_tick),
    .seg_ticks (seg_ticks),
    .seg_end   (seg_end)
  );

  ftx_seq #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .IDX_W  (IDX_W),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .accept        (accept),
    .in_data       (in_data),
    .in_break      (in_break),
    .cfg_len       (cfg_len),
    .cfg_par       (cfg_par),
    .cfg_stop      (cfg_stop),
    .cfg_ovs       (cfg_ovs),
    .cfg_msb_first (cfg_msb_first),
    .seg_end       (seg_end),
    .seg_ticks     (seg_ticks),
    .line_raw      (line_raw),
    .busy          (busy),
    .frame_done    (frame_done)
  );

  assign tx_line = line_raw ^ cfg_tx_inv;
  assign tx_oe   = ~(cfg_auto_tri & ~busy);

endmodule

// File: rtl/ftx_checker.sv
module ftx_checker (
  input logic clk,
  input logic rst_n,
  input logic os_tick,
  input logic cfg_tx_inv,
  input logic cfg_auto_tri,
  input logic cfg_cts_en,
  input logic cfg_cts_inv,
  input logic cts,
  input logic in_ready,
  input logic tx_line,
  input logic tx_oe,
  input logic busy,
  input logic frame_done
);

  logic cts_neg;
  assign cts_neg = cfg_cts_en & (cfg_cts_inv ? ~cts : cts);

  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (tx_line == ~cfg_tx_inv));                                   // R8

  AST_TRI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_auto_tri && !busy) |-> !tx_oe);                                   // R9

  AST_OE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> tx_oe);                                                       // R9

  AST_CTS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_neg && !busy) |=> !busy);                                         // R10

  AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);                                                   // R12

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);                                           // R12

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !busy);                                                 // R12

  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (tx_line == cfg_tx_inv));                              // R2

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !os_tick) |=> ((tx_line ^ cfg_tx_inv) == $past(tx_line ^ cfg_tx_inv))); // R13

endmodule

bind frame_tx ftx_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .os_tick      (os_tick),
  .cfg_tx_inv   (cfg_tx_inv),
  .cfg_auto_tri (cfg_auto_tri),
  .cfg_cts_en   (cfg_cts_en),
  .cfg_cts_inv  (cfg_cts_inv),
  .cts          (cts),
  .in_ready     (in_ready),
  .tx_line      (tx_line),
  .tx_oe        (tx_oe),
  .busy         (busy),
  .frame_done   (frame_done)
);

// File: tb/sim_frame_tx.sv
module sim_frame_tx;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        os_tick;
  logic [3:0]  cfg_len;
  logic [1:0]  cfg_par, cfg_stop, cfg_ovs;
  logic        cfg_msb_first, cfg_tx_inv, cfg_auto_tri, cfg_cts_en, cfg_cts_inv, cts;
  logic [15:0] in_data;
  logic        in_break, in_valid;
  logic        in_ready, tx_line, tx_oe, busy, frame_done;

  int n_checks = 0;
  int n_fail   = 0;
  logic exp_q [0:1023];

  always #2 clk = ~clk;

  frame_tx u0 (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick),
    .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop), .cfg_ovs(cfg_ovs),
    .cfg_msb_first(cfg_msb_first), .cfg_tx_inv(cfg_tx_inv), .cfg_auto_tri(cfg_auto_tri),
    .cfg_cts_en(cfg_cts_en), .cfg_cts_inv(cfg_cts_inv), .cts(cts),
    .in_data(in_data), .in_break(in_break), .in_valid(in_valid), .in_ready(in_ready),
    .tx_line(tx_line), .tx_oe(tx_oe), .busy(busy), .frame_done(frame_done)
  );

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int ticks_for(input logic [1:0] oc);
    case (oc)
      2'd0: return 16;
      2'd1: return 8;
      2'd2: return 6;
      default: return 4;
    endcase
  endfunction

  task automatic run_frame(input logic [15:0] d, input logic [3:0] lc, input logic [1:0] pc,
                           input logic [1:0] sc, input logic [1:0] oc, input logic msb,
                           input logic brk, input int drop_k, input string req);
    int n, nb, tot, stp, bad_k, bad_f;
    logic b, p, got, want;
    n = ticks_for(oc);
    nb = int'(lc) + 3;
    tot = 0;
    p = pc[0];
    for (int r = 0; r < n; r++) begin exp_q[tot] = 1'b0 ^ cfg_tx_inv; tot++; end
    for (int i = 0; i < nb; i++) begin
      b = msb ? d[nb-1-i] : d[i];
      p = p ^ d[i];
      if (brk) b = 1'b0;
      for (int r = 0; r < n; r++) begin exp_q[tot] = b ^ cfg_tx_inv; tot++; end
    end
    if (pc[1]) begin
      b = brk ? 1'b0 : p;
      for (int r = 0; r < n; r++) begin exp_q[tot] = b ^ cfg_tx_inv; tot++; end
    end
    case (sc)
      2'd0: stp = n / 2;
      2'd1: stp = n;
      2'd2: stp = n + n / 2;
      default: stp = 2 * n;
    endcase
    for (int r = 0; r < stp; r++) begin exp_q[tot] = 1'b1 ^ cfg_tx_inv; tot++; end

    @(negedge clk);
    cfg_len = lc; cfg_par = pc; cfg_stop = sc; cfg_ovs = oc; cfg_msb_first = msb;
    check(in_ready == 1'b1, {req, " R12 ready before accept"}, int'(in_ready), 1);
    in_data = d; in_break = brk; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_break = 1'b0; in_data = 16'h0;
    bad_k = -1; bad_f = 0; got = 1'b0; want = 1'b0;
    for (int k = 0; k < tot; k++) begin
      if (tx_line !== exp_q[k] && bad_k < 0) begin bad_k = k; got = tx_line; want = exp_q[k]; end
      if (busy !== 1'b1 || in_ready !== 1'b0 || tx_oe !== 1'b1 || frame_done !== 1'b0) bad_f++;
      if (k == drop_k) cts = cfg_cts_inv ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    if (bad_k >= 0) $display("  mismatch at tick position %0d", bad_k);
    check(bad_k < 0, {req, " line waveform"}, int'(got), int'(want));
    check(bad_f == 0, {req, " R12 R9 busy/ready/oe during frame"}, bad_f, 0);
    check(frame_done == 1'b1 && busy == 1'b0, {req, " R12 done at end"},
          int'({frame_done, busy}), 2);
    check(tx_oe == ~cfg_auto_tri, {req, " R9 oe after frame"}, int'(tx_oe), int'(~cfg_auto_tri));
    if (drop_k >= 0) begin
      check(in_ready == 1'b0, {req, " R11 cts still negated after frame"}, int'(in_ready), 0);
      cts = cfg_cts_inv ? 1'b1 : 1'b0;
    end
    @(negedge clk);
    check(frame_done == 1'b0, {req, " R12 done one clock"}, int'(frame_done), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(tx_line == 1'b1, "R1 idle line", int'(tx_line), 1);
    check(busy == 1'b0 && frame_done == 1'b0, "R1 idle flags", int'({busy, frame_done}), 0);
    check(in_ready == 1'b1 && tx_oe == 1'b1, "R1 ready and oe", int'({in_ready, tx_oe}), 3);
  endtask

  task automatic t_formats();
    run_frame(16'h00A5, 4'd5,  2'd0, 2'd1, 2'd0, 1'b0, 1'b0, -1, "R2 R3 8N1 x16");
    run_frame(16'h0053, 4'd4,  2'd2, 2'd1, 2'd1, 1'b1, 1'b0, -1, "R4 R5 msb 7E1 x8");
    run_frame(16'hB3C1, 4'd13, 2'd3, 2'd3, 2'd3, 1'b0, 1'b0, -1, "R3 R5 R6 16O2 x4");
    run_frame(16'hFFF6, 4'd1,  2'd0, 2'd0, 2'd2, 1'b1, 1'b0, -1, "R3 R6 4-bit half stop x6");
    run_frame(16'h0137, 4'd6,  2'd2, 2'd2, 2'd2, 1'b0, 1'b0, -1, "R5 R6 9E1.5 x6");
    run_frame(16'h0037, 4'd5,  2'd1, 2'd0, 2'd3, 1'b0, 1'b0, -1, "R5 parity code 1 none");
  endtask

  task automatic t_break();
    run_frame(16'h00FF, 4'd5, 2'd3, 2'd1, 2'd3, 1'b0, 1'b1, -1, "R7 break");
  endtask

  task automatic t_invert_tri();
    cfg_tx_inv = 1'b1;
    @(negedge clk);
    check(tx_line == 1'b0, "R8 inverted idle", int'(tx_line), 0);
    run_frame(16'h005A, 4'd5, 2'd2, 2'd1, 2'd3, 1'b0, 1'b0, -1, "R8 inverted frame");
    cfg_tx_inv = 1'b0;
    cfg_auto_tri = 1'b1;
    @(negedge clk);
    check(tx_oe == 1'b0, "R9 tristate idle", int'(tx_oe), 0);
    run_frame(16'h0009, 4'd1, 2'd0, 2'd1, 2'd3, 1'b0, 1'b0, -1, "R9 tristate frame");
    cfg_auto_tri = 1'b0;
  endtask

  task automatic t_cts();
    int bad;
    cfg_cts_en = 1'b1; cfg_cts_inv = 1'b0; cts = 1'b1;
    @(negedge clk);
    in_data = 16'h0055; in_valid = 1'b1; bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (busy !== 1'b0 || in_ready !== 1'b0 || tx_line !== 1'b1) bad++;
    end
    in_valid = 1'b0;
    check(bad == 0, "R10 no start while cts negated", bad, 0);
    cts = 1'b0;
    run_frame(16'h00C3, 4'd5, 2'd0, 2'd1, 2'd3, 1'b0, 1'b0, 15, "R10 R11 cts drop mid-frame");
    cfg_cts_inv = 1'b1; cts = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b0, "R10 inverted cts negated", int'(in_ready), 0);
    cts = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R10 inverted cts asserted", int'(in_ready), 1);
    cfg_cts_en = 1'b0; cts = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R10 cts ignored when disabled", int'(in_ready), 1);
    cfg_cts_inv = 1'b0; cts = 1'b0;
  endtask

  task automatic t_stall();
    int cyc, bad;
    @(negedge clk);
    cfg_len = 4'd5; cfg_par = 2'd0; cfg_stop = 2'd1; cfg_ovs = 2'd3; cfg_msb_first = 1'b0;
    in_data = 16'h0000; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    os_tick = 1'b0; bad = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (tx_line !== 1'b0 || busy !== 1'b1) bad++;
    end
    check(bad == 0, "R13 line holds without ticks", bad, 0);
    os_tick = 1'b1;
    cyc = 42;
    while (frame_done !== 1'b1 && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == 80, "R13 frame stretched by stall", cyc, 80);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; os_tick = 1'b1;
    cfg_len = 4'd5; cfg_par = 2'd0; cfg_stop = 2'd1; cfg_ovs = 2'd0; cfg_msb_first = 1'b0;
    cfg_tx_inv = 1'b0; cfg_auto_tri = 1'b0; cfg_cts_en = 1'b0; cfg_cts_inv = 1'b0; cts = 1'b0;
    in_data = 16'h0; in_break = 1'b0; in_valid = 1'b0;
    t_reset();
    t_formats();
    t_break();
    t_invert_tri();
    t_cts();
    t_stall();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule